// File: doc/BRIEF.md
# PTP Event Frame Field Extractor

This block sits beside an Ethernet byte stream, for example at the boundary between a MAC and a PHY. It follows each frame byte by byte and finds where the precision-time-protocol header begins. The header may be carried directly over Ethernet, inside IPv4/UDP or inside IPv6/UDP, and one VLAN tag may come before the encapsulation. Once the header is found, the block picks out the message type, the sequence number, the 16-bit source port number and the 64-bit clock identity.

For every event message it emits a one-cycle record. The record holds a compact 3-bit event tag, the clock identity, the port number and the sequence number. A timestamp FIFO downstream stores the record next to a time value that is sampled elsewhere. When one-step operation is enabled, the record also marks the message kinds that a one-step transmitter corrects in flight.

The block does not sample time and does not modify frames.

Top module: `ptp_evt_extract`

## Requirements
- R1: A frame whose type field (bytes 12..13, big-endian) is 0x88F7 carries the PTP header directly at byte 14. A frame with any type field other than 0x88F7, 0x0800, 0x86DD or one VLAN tag produces no record.
- R2: A type field of 0x8100 at bytes 12..13 is one VLAN tag. The real type field then sits at bytes 16..17, and every later offset moves by 4. A second VLAN tag produces no record.
- R3: For type 0x0800 the IPv4 header starts at L3 (byte 14, or 18 with a VLAN tag). Its first byte must have 4 in the high nibble and a header length IHL ≥ 5 in the low nibble. The protocol byte at L3+9 must equal 17 (UDP). The PTP header then starts at L3 + 4·IHL + 8. If any of these checks fails, the frame produces no record.
- R4: For type 0x86DD the next-header byte at L3+6 must equal 17. The PTP header then starts at L3+48. Otherwise the frame produces no record.
- R5: The message type is the low nibble of PTP header byte 0. The tag on `rec_tag_o` is 1 for type 0x0, 4 for type 0x1, 2 for type 0x2 and 3 for type 0x3. Any other type produces no record.
- R6: The low nibble of PTP header byte 1 must equal 2. Frames with any other version, including version 1, produce no record. The high nibble of that byte is ignored.
- R7: The clock identity is taken from header bytes 20..27, the port number from bytes 28..29 and the sequence number from bytes 30..31. Each field is big-endian, and each is presented on the record outputs.
- R8: `rec_one_step_o` is 1 on a record only when `one_step_en_i` is 1 in the cycle that the header byte 31 is accepted and the message type is 0x0 or 0x3. In every other case it is 0.
- R9: A frame that ends (through `byte_eof_i`) before header byte 31 produces no record. Bytes presented between an end of frame and the next `byte_sof_i` are ignored.
- R10: `rec_vld_o` is high for exactly one cycle, which is the cycle right after the clock edge that accepts header byte 31. Idle cycles inside a frame only delay it.
- R11: While reset is active and right after it, `rec_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| one_step_en_i | input | 1 | Enable the one-step marking of sync and peer-delay-response records |
| byte_vld_i | input | 1 | A stream byte is presented this cycle |
| byte_sof_i | input | 1 | The byte presented is the first byte of a frame |
| byte_eof_i | input | 1 | The byte presented is the last byte of a frame |
| byte_data_i | input | 8 | Stream byte |
| rec_vld_o | output | 1 | One-cycle record strobe |
| rec_tag_o | output | 3 | Event tag (1..4) |
| rec_one_step_o | output | 1 | Record qualifies for one-step correction |
| rec_clk_id_o | output | 64 | Clock identity |
| rec_port_o | output | 16 | Source port number |
| rec_seq_o | output | 16 | Sequence number |

## Verification
The hardest case to reach from the ports is an IPv4 frame whose options make the header offset depend on a byte that arrives only mid-frame. The same stimulus must also show that the protocol check, placed after that byte, still vetoes the record. The bench builds frames in an array with chosen IHL, VLAN and protocol values and streams them with idle gaps.

A second hard case is a frame cut short by end-of-frame, followed by stray bytes that look like the rest of the header. Only a position tracker that honours frame boundaries stays silent there.

// File: rtl/ptp_evt_pkg.sv
package ptp_evt_pkg;

  typedef enum logic [1:0] {
    ENC_NONE = 2'd0,
    ENC_L2   = 2'd1,
    ENC_IP4  = 2'd2,
    ENC_IP6  = 2'd3
  } encap_e;

  localparam int ETH_HDR_LEN  = 14;
  localparam int VLAN_LEN     = 4;
  localparam int UDP_LEN      = 8;
  localparam int IP6_LEN      = 40;
  localparam int ETY_POS      = 12;
  localparam int IP4_PROTO_AT = 9;
  localparam int IP6_NH_AT    = 6;

  localparam logic [15:0] ETY_VLAN = 16'h8100;
  localparam logic [15:0] ETY_PTP  = 16'h88F7;
  localparam logic [15:0] ETY_IP4  = 16'h0800;
  localparam logic [15:0] ETY_IP6  = 16'h86DD;
  localparam logic [7:0]  PROTO_UDP = 8'd17;

  // offsets inside the PTP header
  localparam int HOFF_TYPE = 0;
  localparam int HOFF_VER  = 1;
  localparam int HOFF_CLK  = 20;
  localparam int HOFF_PORT = 28;
  localparam int HOFF_SEQ  = 30;
  localparam int HOFF_LAST = 31;
  localparam logic [3:0] PTP_VER2 = 4'd2;

  function automatic logic [2:0] type_to_tag(input logic [3:0] mtype);
    case (mtype)
      4'h0:    return 3'd1;
      4'h2:    return 3'd2;
      4'h3:    return 3'd3;
      4'h1:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic one_step_type(input logic [3:0] mtype);
    return (mtype == 4'h0) || (mtype == 4'h3);
  endfunction

endpackage

// File: rtl/ptp_evt_framer.sv
module ptp_evt_framer #(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             acc_o,
  output logic             first_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             in_frame_q;
  logic [POS_W-1:0] pos_q;

  assign acc_o   = vld_i && (sof_i || in_frame_q);
  assign first_o = vld_i && sof_i;
  assign pos_o   = sof_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else if (acc_o) begin
      in_frame_q <= !eof_i;
      pos_q      <= (pos_o == POS_MAX) ? pos_o : pos_o + 1'b1;
    end
  end

endmodule

// File: rtl/ptp_evt_locator.sv
module ptp_evt_locator
  import ptp_evt_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             first_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       data_i,
  output logic             off_vld_o,
  output logic [POS_W-1:0] off_o,
  output logic             path_ok_o
);
  localparam logic [POS_W-1:0] L3_PLAIN  = POS_W'(ETH_HDR_LEN);
  localparam logic [POS_W-1:0] L3_TAGGED = POS_W'(ETH_HDR_LEN + VLAN_LEN);
  localparam logic [POS_W-1:0] ET_PLAIN  = POS_W'(ETY_POS);
  localparam logic [POS_W-1:0] ET_TAGGED = POS_W'(ETY_POS + VLAN_LEN);
  localparam logic [POS_W-1:0] UDP_W     = POS_W'(UDP_LEN);
  localparam logic [POS_W-1:0] IP6_SKIP  = POS_W'(IP6_LEN + UDP_LEN);
  localparam logic [POS_W-1:0] PROTO_W   = POS_W'(IP4_PROTO_AT);
  localparam logic [POS_W-1:0] NH_W      = POS_W'(IP6_NH_AT);

  logic             vlan_q;
  encap_e           enc_q;
  logic [7:0]       ety_hi_q;
  logic [POS_W-1:0] off_q;
  logic             off_vld_q;
  logic             ok_q;

  logic [POS_W-1:0] l3_base;
  logic [POS_W-1:0] ety_at;
  logic [15:0]      ety;

  assign l3_base = vlan_q ? L3_TAGGED : L3_PLAIN;
  assign ety_at  = vlan_q ? ET_TAGGED : ET_PLAIN;
  assign ety     = {ety_hi_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vlan_q    <= 1'b0;
      enc_q     <= ENC_NONE;
      ety_hi_q  <= '0;
      off_q     <= '0;
      off_vld_q <= 1'b0;
      ok_q      <= 1'b0;
    end else if (acc_i) begin
      if (first_i) begin
        vlan_q    <= 1'b0;
        enc_q     <= ENC_NONE;
        off_vld_q <= 1'b0;
        ok_q      <= 1'b0;
      end else begin
        if (pos_i == ety_at) ety_hi_q <= data_i;
        if (pos_i == ety_at + 1'b1) begin
          case (ety)
            ETY_VLAN: if (!vlan_q) vlan_q <= 1'b1;
            ETY_PTP: begin
              enc_q     <= ENC_L2;
              off_q     <= l3_base;
              off_vld_q <= 1'b1;
              ok_q      <= 1'b1;
            end
            ETY_IP4: enc_q <= ENC_IP4;
            ETY_IP6: begin
              enc_q     <= ENC_IP6;
              off_q     <= l3_base + IP6_SKIP;
              off_vld_q <= 1'b1;
            end
            default: ;
          endcase
        end
        if (enc_q == ENC_IP4 && pos_i == l3_base) begin
          if (data_i[7:4] == 4'd4 && data_i[3:0] >= 4'd5) begin
            off_q     <= l3_base + POS_W'({data_i[3:0], 2'b00}) + UDP_W;
            off_vld_q <= 1'b1;
          end else begin
            enc_q <= ENC_NONE;
          end
        end
        if (enc_q == ENC_IP4 && pos_i == l3_base + PROTO_W) ok_q <= (data_i == PROTO_UDP);
        if (enc_q == ENC_IP6 && pos_i == l3_base + NH_W)    ok_q <= (data_i == PROTO_UDP);
      end
    end
  end

  assign off_vld_o = off_vld_q;
  assign off_o     = off_q;
  assign path_ok_o = ok_q;

endmodule

// File: rtl/ptp_evt_capture.sv
module ptp_evt_capture
  import ptp_evt_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             first_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       data_i,
  input  logic             off_vld_i,
  input  logic [POS_W-1:0] off_i,
  input  logic             path_ok_i,
  input  logic             one_step_en_i,
  output logic             rec_vld_o,
  output logic [2:0]       rec_tag_o,
  output logic             rec_one_step_o,
  output logic [63:0]      rec_clk_id_o,
  output logic [15:0]      rec_port_o,
  output logic [15:0]      rec_seq_o
);
  localparam logic [POS_W-1:0] R_TYPE = POS_W'(HOFF_TYPE);
  localparam logic [POS_W-1:0] R_VER  = POS_W'(HOFF_VER);
  localparam logic [POS_W-1:0] R_CLK  = POS_W'(HOFF_CLK);
  localparam logic [POS_W-1:0] R_PORT = POS_W'(HOFF_PORT);
  localparam logic [POS_W-1:0] R_SEQ  = POS_W'(HOFF_SEQ);
  localparam logic [POS_W-1:0] R_LAST = POS_W'(HOFF_LAST);

  logic [POS_W-1:0] rel;
  logic             in_hdr;
  logic [2:0]       tag_now;

  logic [3:0]  type_q;
  logic [3:0]  ver_q;
  logic [63:0] clk_q;
  logic [15:0] port_q;
  logic [15:0] seq_q;
  logic [2:0]  tag_q;
  logic        os_q;
  logic        vld_q;

  assign rel     = pos_i - off_i;
  assign in_hdr  = acc_i && !first_i && off_vld_i && (pos_i >= off_i);
  assign tag_now = type_to_tag(type_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      ver_q  <= '0;
      clk_q  <= '0;
      port_q <= '0;
      seq_q  <= '0;
      tag_q  <= '0;
      os_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (in_hdr) begin
        if (rel == R_TYPE) type_q <= data_i[3:0];
        if (rel == R_VER)  ver_q  <= data_i[3:0];
        if (rel >= R_CLK && rel < R_PORT) clk_q  <= {clk_q[55:0], data_i};
        if (rel >= R_PORT && rel < R_SEQ) port_q <= {port_q[7:0], data_i};
        if (rel >= R_SEQ && rel <= R_LAST) seq_q <= {seq_q[7:0], data_i};
        if (rel == R_LAST && path_ok_i && ver_q == PTP_VER2 && tag_now != 3'd0) begin
          vld_q <= 1'b1;
          tag_q <= tag_now;
          os_q  <= one_step_en_i && one_step_type(type_q);
        end
      end
    end
  end

  assign rec_vld_o      = vld_q;
  assign rec_tag_o      = tag_q;
  assign rec_one_step_o = os_q;
  assign rec_clk_id_o   = clk_q;
  assign rec_port_o     = port_q;
  assign rec_seq_o      = seq_q;

endmodule

// File: rtl/ptp_evt_extract.sv
module ptp_evt_extract #(
  parameter int POS_W = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        one_step_en_i,
  input  logic        byte_vld_i,
  input  logic        byte_sof_i,
  input  logic        byte_eof_i,
  input  logic [7:0]  byte_data_i,
  output logic        rec_vld_o,
  output logic [2:0]  rec_tag_o,
  output logic        rec_one_step_o,
  output logic [63:0] rec_clk_id_o,
  output logic [15:0] rec_port_o,
  output logic [15:0] rec_seq_o
);
  logic             acc;
  logic             first;
  logic [POS_W-1:0] pos;
  logic             off_vld;
  logic [POS_W-1:0] off;
  logic             path_ok;

  ptp_evt_framer #(.POS_W(POS_W)) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (byte_vld_i),
    .sof_i   (byte_sof_i),
    .eof_i   (byte_eof_i),
    .acc_o   (acc),
    .first_o (first),
    .pos_o   (pos)
  );

  ptp_evt_locator #(.POS_W(POS_W)) u_locator (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .first_i   (first),
    .pos_i     (pos),
    .data_i    (byte_data_i),
    .off_vld_o (off_vld),
    .off_o     (off),
    .path_ok_o (path_ok)
  );

  ptp_evt_capture #(.POS_W(POS_W)) u_capture (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_i          (acc),
    .first_i        (first),
    .pos_i          (pos),
    .data_i         (byte_data_i),
    .off_vld_i      (off_vld),
    .off_i          (off),
    .path_ok_i      (path_ok),
    .one_step_en_i  (one_step_en_i),
    .rec_vld_o      (rec_vld_o),
    .rec_tag_o      (rec_tag_o),
    .rec_one_step_o (rec_one_step_o),
    .rec_clk_id_o   (rec_clk_id_o),
    .rec_port_o     (rec_port_o),
    .rec_seq_o      (rec_seq_o)
  );

endmodule

// File: rtl/ptp_evt_extract_chk.sv
module ptp_evt_extract_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       one_step_en_i,
  input logic       byte_vld_i,
  input logic       rec_vld_o,
  input logic [2:0] rec_tag_o,
  input logic       rec_one_step_o
);

  p_vld_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |=> !rec_vld_o);

  p_vld_after_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> $past(byte_vld_i));

  p_tag_known_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_vld_o |-> (rec_tag_o >= 3'd1 && rec_tag_o <= 3'd4));

  p_one_step_kind_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_vld_o && rec_one_step_o) |-> (rec_tag_o == 3'd1 || rec_tag_o == 3'd3));

  p_one_step_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_vld_o && !$past(one_step_en_i)) |-> !rec_one_step_o);

endmodule

bind ptp_evt_extract ptp_evt_extract_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .one_step_en_i  (one_step_en_i),
  .byte_vld_i     (byte_vld_i),
  .rec_vld_o      (rec_vld_o),
  .rec_tag_o      (rec_tag_o),
  .rec_one_step_o (rec_one_step_o)
);

// File: tb/ptp_evt_extract_bench.sv
module ptp_evt_extract_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        one_step_en = 1'b0;
  logic        vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0]  data = '0;
  logic        rec_vld;
  logic [2:0]  rec_tag;
  logic        rec_os;
  logic [63:0] rec_clk;
  logic [15:0] rec_port, rec_seq;

  always #2 clk = ~clk;

  ptp_evt_extract u_ptp_evt_extract (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .one_step_en_i  (one_step_en),
    .byte_vld_i     (vld),
    .byte_sof_i     (sof),
    .byte_eof_i     (eof),
    .byte_data_i    (data),
    .rec_vld_o      (rec_vld),
    .rec_tag_o      (rec_tag),
    .rec_one_step_o (rec_os),
    .rec_clk_id_o   (rec_clk),
    .rec_port_o     (rec_port),
    .rec_seq_o      (rec_seq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  // record monitor, samples at the falling edge
  int          rec_cnt = 0;
  int          got_cyc = 0;
  logic [2:0]  got_tag;
  logic        got_os;
  logic [63:0] got_clk;
  logic [15:0] got_port, got_seq;

  always @(negedge clk) begin
    if (rst_n && rec_vld) begin
      rec_cnt  = rec_cnt + 1;
      got_cyc  = cyc;
      got_tag  = rec_tag;
      got_os   = rec_os;
      got_clk  = rec_clk;
      got_port = rec_port;
      got_seq  = rec_seq;
    end
  end

  logic [7:0]  frm [0:255];
  int          frm_len;
  int          hdr_pos;
  int          last_cyc;
  logic [63:0] e_clk;
  logic [15:0] e_port, e_seq;

  task automatic chk_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // enc: 0 raw, 1 ipv4, 2 ipv6, 3 other type field
  task automatic build(input int enc, input bit vlan, input int ihl, input logic [7:0] proto,
                       input logic [3:0] mtype, input logic [3:0] ver,
                       input logic [63:0] cid, input logic [15:0] pn, input logic [15:0] sq);
    int p;
    int l3;
    for (int i = 0; i < 256; i++) frm[i] = 8'h5A ^ 8'(i * 7);
    p = 12;
    if (vlan) begin
      frm[12] = 8'h81; frm[13] = 8'h00; frm[14] = 8'h20; frm[15] = 8'h05;
      p = 16;
    end
    l3 = p + 2;
    case (enc)
      0: begin frm[p] = 8'h88; frm[p+1] = 8'hF7; hdr_pos = l3; end
      1: begin
        frm[p] = 8'h08; frm[p+1] = 8'h00;
        frm[l3] = {4'h4, 4'(ihl)}; frm[l3+9] = proto;
        hdr_pos = l3 + ihl * 4 + 8;
      end
      2: begin
        frm[p] = 8'h86; frm[p+1] = 8'hDD;
        frm[l3] = 8'h60; frm[l3+6] = proto;
        hdr_pos = l3 + 48;
      end
      default: begin frm[p] = 8'h08; frm[p+1] = 8'h06; hdr_pos = l3 + 28; end
    endcase
    frm[hdr_pos]   = {4'hB, mtype};
    frm[hdr_pos+1] = {4'h1, ver};
    for (int k = 0; k < 8; k++) frm[hdr_pos+20+k] = cid[63-8*k -: 8];
    frm[hdr_pos+28] = pn[15:8]; frm[hdr_pos+29] = pn[7:0];
    frm[hdr_pos+30] = sq[15:8]; frm[hdr_pos+31] = sq[7:0];
    frm_len = hdr_pos + 44;
    e_clk = cid; e_port = pn; e_seq = sq;
  endtask

  // drive bytes [from, to); sof on index 0, eof on index len-1 when mark_eof
  task automatic drive(input int from, input int to, input int len, input bit mark_eof, input int gap);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      if (gap > 0 && (i % gap) == gap - 1) begin
        vld = 1'b0; sof = 1'b0; eof = 1'b0;
        @(negedge clk);
      end
      vld  = 1'b1;
      sof  = (i == 0);
      eof  = mark_eof && (i == len - 1);
      data = frm[i];
      if (i == hdr_pos + 31) last_cyc = cyc;
    end
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input int gap);
    rec_cnt = 0;
    drive(0, frm_len, frm_len, 1'b1, gap);
  endtask

  task automatic expect_rec(input string req, input logic [2:0] tag, input logic os);
    chk_eq(req, "record count", 64'(rec_cnt), 64'd1);
    chk_eq(req, "tag", 64'(got_tag), 64'(tag));
    chk_eq(req, "one-step", 64'(got_os), 64'(os));
    chk_eq(req, "clock id", got_clk, e_clk);
    chk_eq(req, "port", 64'(got_port), 64'(e_port));
    chk_eq(req, "sequence", 64'(got_seq), 64'(e_seq));
    chk_eq(req, "record cycle", 64'(got_cyc), 64'(last_cyc + 1));
  endtask

  task automatic expect_none(input string req);
    chk_eq(req, "record count", 64'(rec_cnt), 64'd0);
  endtask

  task automatic t_reset;
    chk_eq("R11", "valid in reset", 64'(rec_vld), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R11", "valid after reset", 64'(rec_vld), 64'd0);
  endtask

  task automatic t_raw_sync;  // R1 R5 R7 R10
    one_step_en = 1'b0;
    build(0, 0, 5, 8'd17, 4'h0, 4'd2, 64'h0011_2233_4455_6677, 16'h0102, 16'hA1B2);
    send(0);
    expect_rec("R1", 3'd1, 1'b0);
  endtask

  task automatic t_vlan_delay_req;  // R2 R5
    build(0, 1, 5, 8'd17, 4'h1, 4'd2, 64'hFEDC_BA98_7654_3210, 16'h8001, 16'h0042);
    send(0);
    expect_rec("R2", 3'd4, 1'b0);
  endtask

  task automatic t_ip4_pdreq_gaps;  // R3 R10
    build(1, 0, 5, 8'd17, 4'h2, 4'd2, 64'h1357_9BDF_0246_8ACE, 16'h0003, 16'hFFFF);
    send(3);
    expect_rec("R3", 3'd2, 1'b0);
  endtask

  task automatic t_ip4_opts_vlan_pdresp;  // R3 R8
    one_step_en = 1'b1;
    build(1, 1, 7, 8'd17, 4'h3, 4'd2, 64'hCAFE_0000_BEEF_0001, 16'h7FFE, 16'h1234);
    send(5);
    expect_rec("R8", 3'd3, 1'b1);
  endtask

  task automatic t_ip6_sync_onestep;  // R4 R8
    one_step_en = 1'b1;
    build(2, 0, 5, 8'd17, 4'h0, 4'd2, 64'hA5A5_5A5A_0F0F_F0F0, 16'h0BAD, 16'h0001);
    send(0);
    expect_rec("R4", 3'd1, 1'b1);
  endtask

  task automatic t_onestep_other_type;  // R8
    one_step_en = 1'b1;
    build(0, 0, 5, 8'd17, 4'h1, 4'd2, 64'h1, 16'h2, 16'h3);
    send(0);
    expect_rec("R8", 3'd4, 1'b0);
    one_step_en = 1'b0;
  endtask

  task automatic t_unmapped_type;  // R5
    build(0, 0, 5, 8'd17, 4'h8, 4'd2, 64'h9, 16'h9, 16'h9);
    send(0);
    expect_none("R5");
  endtask

  task automatic t_version_one;  // R6
    build(1, 0, 5, 8'd17, 4'h0, 4'd1, 64'h9, 16'h9, 16'h9);
    send(0);
    expect_none("R6");
  endtask

  task automatic t_bad_transport;  // R3 R4
    build(1, 0, 6, 8'd6, 4'h0, 4'd2, 64'h9, 16'h9, 16'h9);
    send(0);
    expect_none("R3");
    build(2, 1, 5, 8'd6, 4'h3, 4'd2, 64'h9, 16'h9, 16'h9);
    send(0);
    expect_none("R4");
  endtask

  task automatic t_other_ethertype;  // R1
    build(3, 0, 5, 8'd17, 4'h0, 4'd2, 64'h9, 16'h9, 16'h9);
    send(0);
    expect_none("R1");
  endtask

  task automatic t_truncated;  // R9
    build(0, 0, 5, 8'd17, 4'h0, 4'd2, 64'h77, 16'h66, 16'h55);
    rec_cnt = 0;
    drive(0, hdr_pos + 31, hdr_pos + 31, 1'b1, 0);
    drive(hdr_pos + 31, frm_len, frm_len, 1'b0, 0);
    expect_none("R9");
    send(0);
    expect_rec("R9", 3'd1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_raw_sync();
    t_vlan_delay_req();
    t_ip4_pdreq_gaps();
    t_ip4_opts_vlan_pdresp();
    t_ip6_sync_onestep();
    t_onestep_other_type();
    t_unmapped_type();
    t_version_one();
    t_bad_transport();
    t_other_ethertype();
    t_truncated();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule